// File: doc/BRIEF.md
# Banked Wavefront Scratch Memory

This block is the shared scratch memory for a single 32-lane wavefront. Storage is spread over independent banks of 32-bit words, and each bank can take one read and one write in every cycle. A request brings one word address per lane, a lane enable mask, one operation code that applies to every enabled lane, and one write operand per lane. A crossbar steers each enabled lane to its bank and sends each bank result back to the lanes that asked for it.

When two or more enabled lanes need different words in the same bank, the block detects it. It serves those lanes over extra passes and holds `req_ready` low until every lane has been served. Lanes that read the same word share one bank access, and the word is broadcast to all of them. Each bank has its own atomic unit. This unit reads the old word, combines it with the operand of the lane being served, writes the result back, and returns the old word to that lane.

The number of rows is a parameter. The full-size array uses 512 rows per bank. The default is set smaller so the block elaborates quickly.

Top module: `lds_banked_mem`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_done` is 0 and every bit of `rsp_data` is 0.
- R2: Each lane address is a word address. Its low 5 bits choose the bank, and the bits above them choose the row inside that bank. Lanes whose words lie in different banks never delay one another.
- R3: A request is accepted on a rising edge where `req_valid` and `req_ready` are both 1. If it needs a single pass, `rsp_done` is 1 for the cycle that follows the next rising edge.
- R4: The pass count for a request is the largest per-bank count, taken over all banks. For a read, the count is the number of distinct words requested in that bank. For every other code, it is the number of enabled lanes in that bank. `rsp_done` rises that many edges after acceptance, and `req_ready` stays 0 until then.
- R5: Op code 0 reads. Every enabled lane receives the word it addresses, and lanes that read the same word are served in one pass.
- R6: Op code 1 writes the lane operand. For every code other than 0, each enabled lane receives the word's content from just before its own update. Disabled lanes return 0 and leave memory unchanged.
- R7: When several enabled lanes update the same word, the updates are applied one after another in ascending lane order, and each lane sees the result left by the lanes below it.
- R8: Integer atomic codes are: 2 add (modulo 2^32), 3 signed min, 4 signed max, 5 and, 6 or, 7 xor, 8 exchange.
- R9: Codes 9 and 10 are float32 min and max. -0 orders below +0. A NaN operand leaves the stored word as it is, and a NaN in memory is replaced by a non-NaN operand.
- R10: `rsp_done` is high for exactly one cycle. `rsp_data` then holds its value until the next request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_op | input | 4 | Operation code for all lanes |
| req_mask | input | LANES (32) | Per-lane enable |
| req_waddr | input | LANES*WA (352) | Per-lane word address, lane 0 in the low bits |
| req_wdata | input | LANES*32 (1024) | Per-lane write or atomic operand |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_data | output | LANES*32 (1024) | Per-lane result, lane 0 in the low bits |

## Verification
The hardest situation to reach is a long replay in which the pass count depends on both the operation and the pattern of repeated addresses. An example is a bank hit by a mix of shared and distinct words, or thirty-two atomics chained on one word. Uniformly random addresses almost never produce these. The stimulus therefore draws a fresh mode for each request: fully random words, a pool of four words, or a single bank with random rows. Directed cases add the full 32-pass single-bank read, an all-lane broadcast, a 32-step atomic add chain, and NaN and signed-zero operands for the float codes.

// File: rtl/lds_pkg.sv
package lds_pkg;

    typedef enum logic [3:0] {
        OP_READ  = 4'd0,
        OP_WRITE = 4'd1,
        OP_ADD   = 4'd2,
        OP_SMIN  = 4'd3,
        OP_SMAX  = 4'd4,
        OP_AND   = 4'd5,
        OP_OR    = 4'd6,
        OP_XOR   = 4'd7,
        OP_XCHG  = 4'd8,
        OP_FMIN  = 4'd9,
        OP_FMAX  = 4'd10
    } lds_op_e;

    function automatic logic f_is_nan(input logic [31:0] x);
        return (&x[30:23]) && (|x[22:0]);
    endfunction

    // true when a orders strictly below b as float32 (-0 below +0)
    function automatic logic f_less(input logic [31:0] a, input logic [31:0] b);
        if (a[31] != b[31])
            return a[31];
        else if (!a[31])
            return a[30:0] < b[30:0];
        else
            return a[30:0] > b[30:0];
    endfunction

endpackage

// File: rtl/lds_atomic_alu.sv
module lds_atomic_alu
    import lds_pkg::*;
(
    input  logic [3:0]  op_i,
    input  logic [31:0] old_i,
    input  logic [31:0] operand_i,
    output logic [31:0] result_o
);

    always_comb begin
        result_o = old_i;
        case (lds_op_e'(op_i))
            OP_WRITE, OP_XCHG: result_o = operand_i;
            OP_ADD:  result_o = old_i + operand_i;
            OP_SMIN: result_o = ($signed(operand_i) < $signed(old_i)) ? operand_i : old_i;
            OP_SMAX: result_o = ($signed(operand_i) > $signed(old_i)) ? operand_i : old_i;
            OP_AND:  result_o = old_i & operand_i;
            OP_OR:   result_o = old_i | operand_i;
            OP_XOR:  result_o = old_i ^ operand_i;
            OP_FMIN: begin
                if (f_is_nan(operand_i))   result_o = old_i;
                else if (f_is_nan(old_i))  result_o = operand_i;
                else                       result_o = f_less(operand_i, old_i) ? operand_i : old_i;
            end
            OP_FMAX: begin
                if (f_is_nan(operand_i))   result_o = old_i;
                else if (f_is_nan(old_i))  result_o = operand_i;
                else                       result_o = f_less(old_i, operand_i) ? operand_i : old_i;
            end
            default: result_o = old_i;
        endcase
    end

endmodule

// File: rtl/lds_bank.sv
module lds_bank
    import lds_pkg::*;
#(
    parameter  int ROWS     = 64,
    localparam int ROW_BITS = $clog2(ROWS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en_i,
    input  logic [3:0]          op_i,
    input  logic [ROW_BITS-1:0] row_i,
    input  logic [31:0]         operand_i,
    output logic [31:0]         rdata_o
);

    logic [31:0] mem_q [ROWS];
    logic [31:0] wr_val_d;

    assign rdata_o = mem_q[row_i];

    lds_atomic_alu u_alu (
        .op_i      (op_i),
        .old_i     (rdata_o),
        .operand_i (operand_i),
        .result_o  (wr_val_d)
    );

    always_ff @(posedge clk) begin
        if (en_i && op_i != OP_READ)
            mem_q[row_i] <= wr_val_d;
    end

    AST_FMIN_NAN_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && op_i == OP_FMIN && f_is_nan(operand_i)) |-> (wr_val_d == rdata_o)); // R9
    AST_FMAX_NAN_REPLACED: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && op_i == OP_FMAX && f_is_nan(rdata_o) && !f_is_nan(operand_i))
            |-> (wr_val_d == operand_i)); // R9

endmodule

// File: rtl/lds_banked_mem.sv
module lds_banked_mem
    import lds_pkg::*;
#(
    parameter  int LANES     = 32,
    parameter  int BANKS     = 32,
    parameter  int ROWS      = 64,
    localparam int BANK_BITS = $clog2(BANKS),
    localparam int ROW_BITS  = $clog2(ROWS),
    localparam int WA        = BANK_BITS + ROW_BITS
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [3:0]            req_op,
    input  logic [LANES-1:0]      req_mask,
    input  logic [LANES*WA-1:0]   req_waddr,
    input  logic [LANES*32-1:0]   req_wdata,
    output logic                  rsp_done,
    output logic [LANES*32-1:0]   rsp_data
);

    localparam int LIDX = $clog2(LANES);

    typedef struct packed {
        logic                        busy;
        logic                        done;
        logic [3:0]                  op;
        logic [LANES-1:0]            pend;
        logic [LANES-1:0][WA-1:0]    waddr;
        logic [LANES-1:0][31:0]      wdata;
        logic [LANES-1:0][31:0]      rdata;
    } state_t;

    state_t st_q, st_d;

    logic [BANK_BITS-1:0]           lane_bank [LANES];
    logic [ROW_BITS-1:0]            lane_row  [LANES];
    logic [BANKS-1:0]               lead_vld;
    logic [LIDX-1:0]                lead_idx  [BANKS];
    logic [LANES-1:0]               served;
    logic [BANKS-1:0][LANES-1:0]    lane_in_bank;
    logic [31:0]                    bk_rdata  [BANKS];

    // address split per lane
    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            lane_bank[l] = st_q.waddr[l][BANK_BITS-1:0];
            lane_row[l]  = st_q.waddr[l][WA-1:BANK_BITS];
            for (int b = 0; b < BANKS; b++)
                lane_in_bank[b][l] = (lane_bank[l] == BANK_BITS'(b));
        end
    end

    // lowest pending lane owns each bank for this pass
    always_comb begin
        for (int b = 0; b < BANKS; b++) begin
            lead_vld[b] = 1'b0;
            lead_idx[b] = '0;
            for (int l = LANES - 1; l >= 0; l--) begin
                if (st_q.pend[l] && lane_in_bank[b][l]) begin
                    lead_vld[b] = 1'b1;
                    lead_idx[b] = LIDX'(l);
                end
            end
        end
    end

    // owner plus, for reads, every lane that wants the same word
    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            served[l] = st_q.busy && st_q.pend[l] &&
                ((lead_idx[lane_bank[l]] == LIDX'(l)) ||
                 (st_q.op == OP_READ &&
                  st_q.waddr[l] == st_q.waddr[lead_idx[lane_bank[l]]]));
        end
    end

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        lds_bank #(.ROWS(ROWS)) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .en_i      (st_q.busy && lead_vld[b]),
            .op_i      (st_q.op),
            .row_i     (lane_row[lead_idx[b]]),
            .operand_i (st_q.wdata[lead_idx[b]]),
            .rdata_o   (bk_rdata[b])
        );

        AST_ONE_UPDATE_PER_BANK: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q.busy && st_q.op != OP_READ)
                |-> ($countones(served & lane_in_bank[b]) <= 1)); // R7
    end

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (st_q.busy) begin
            for (int l = 0; l < LANES; l++)
                if (served[l])
                    st_d.rdata[l] = bk_rdata[lane_bank[l]];
            st_d.pend = st_q.pend & ~served;
            if ((st_q.pend & ~served) == '0) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end
        end else if (req_valid) begin
            st_d.busy  = 1'b1;
            st_d.op    = req_op;
            st_d.pend  = req_mask;
            st_d.rdata = '0;
            for (int l = 0; l < LANES; l++) begin
                st_d.waddr[l] = req_waddr[l*WA +: WA];
                st_d.wdata[l] = req_wdata[l*32 +: 32];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req_ready = !st_q.busy;
    assign rsp_done  = st_q.done;
    for (genvar l = 0; l < LANES; l++) begin : g_rsp
        assign rsp_data[l*32 +: 32] = st_q.rdata[l];
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done); // R10
    AST_PASS_PROGRESS: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |=> (!st_q.busy ||
            (((st_q.pend & ~$past(st_q.pend)) == '0) && st_q.pend != $past(st_q.pend)))); // R4
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> (st_q.pend == '0 && req_ready)); // R3
    AST_ACCEPT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready); // R4

endmodule

// File: tb/lds_banked_mem_test.sv
module lds_banked_mem_test;

    localparam int LANES = 32;
    localparam int BANKS = 32;
    localparam int ROWS  = 64;
    localparam int WA    = 11;
    localparam int WORDS = BANKS * ROWS;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  req_valid = 1'b0;
    logic [3:0]            req_op = '0;
    logic [LANES-1:0]      req_mask = '0;
    logic [LANES*WA-1:0]   req_waddr = '0;
    logic [LANES*32-1:0]   req_wdata = '0;
    logic                  req_ready;
    logic                  rsp_done;
    logic [LANES*32-1:0]   rsp_data;

    lds_banked_mem #(.LANES(LANES), .BANKS(BANKS), .ROWS(ROWS)) uut (
        .clk, .rst_n, .req_valid, .req_ready, .req_op, .req_mask,
        .req_waddr, .req_wdata, .rsp_done, .rsp_data
    );

    always #10 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit ended  = 0;
    logic [31:0]   mem_m [WORDS];
    logic [WA-1:0] ta [LANES];
    logic [31:0]   td [LANES];

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            checks++; fails++;
            $display("FAIL R3 watchdog actual=%0d expected<150000", cyc);
            finish_run();
        end
    end

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic b_nan(input logic [31:0] x);
        return x[30:23] == 8'hFF && x[22:0] != 0;
    endfunction

    function automatic logic [31:0] b_key(input logic [31:0] x);
        return x[31] ? ~x : (x | 32'h8000_0000);
    endfunction

    function automatic logic [31:0] b_apply(input logic [3:0] op, input logic [31:0] m, input logic [31:0] d);
        case (op)
            4'd1, 4'd8: return d;
            4'd2: return m + d;
            4'd3: return ($signed(d) < $signed(m)) ? d : m;
            4'd4: return ($signed(d) > $signed(m)) ? d : m;
            4'd5: return m & d;
            4'd6: return m | d;
            4'd7: return m ^ d;
            4'd9, 4'd10: begin
                if (b_nan(d)) return m;
                if (b_nan(m)) return d;
                if (op == 4'd9) return (b_key(d) < b_key(m)) ? d : m;
                return (b_key(d) > b_key(m)) ? d : m;
            end
            default: return m;
        endcase
    endfunction

    function automatic string op_tag(input logic [3:0] op);
        if (op == 0) return "R5";
        if (op == 1) return "R6";
        if (op >= 9) return "R9";
        return "R8";
    endfunction

    task automatic run_req(input logic [3:0] op, input logic [31:0] mask, input string tag, input bit cmp);
        logic [31:0] exp_r [LANES];
        int cnt [BANKS];
        int p, n;
        logic [31:0] held;
        for (int b = 0; b < BANKS; b++) cnt[b] = 0;
        for (int l = 0; l < LANES; l++) begin
            if (mask[l]) begin
                bit dup = 0;
                if (op == 0)
                    for (int m = 0; m < l; m++)
                        if (mask[m] && ta[m] == ta[l]) dup = 1;
                if (!dup) cnt[ta[l][4:0]]++;
            end
        end
        p = 1;
        for (int b = 0; b < BANKS; b++) if (cnt[b] > p) p = cnt[b];
        for (int l = 0; l < LANES; l++) begin
            exp_r[l] = '0;
            if (mask[l]) begin
                exp_r[l] = mem_m[ta[l]];
                if (op != 0) mem_m[ta[l]] = b_apply(op, mem_m[ta[l]], td[l]);
            end
        end
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_op = op; req_mask = mask; req_valid = 1'b1;
        for (int l = 0; l < LANES; l++) begin
            req_waddr[l*WA +: WA] = ta[l];
            req_wdata[l*32 +: 32] = td[l];
        end
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R4", "ready during service", {31'd0, req_ready}, 32'd0);
        n = 0;
        do begin
            @(posedge clk); @(negedge clk); n++;
        end while (!rsp_done && n < 40);
        chk(p == 1 ? "R3" : "R4", "pass count", n, p);
        if (cmp)
            for (int l = 0; l < LANES; l++)
                chk(mask[l] ? tag : "R6", "lane data", rsp_data[l*32 +: 32], exp_r[l]);
        held = rsp_data[31:0];
        @(negedge clk);
        chk("R10", "done width", {31'd0, rsp_done}, 32'd0);
        chk("R10", "data hold", rsp_data[31:0], held);
    endtask

    initial begin
        void'($urandom(32'h5EED_0A11));
        repeat (3) @(negedge clk);
        chk("R1", "ready", {31'd0, req_ready}, 32'd1);
        chk("R1", "done", {31'd0, rsp_done}, 32'd0);
        chk("R1", "data", {31'd0, |rsp_data}, 32'd0);
        rst_n = 1'b1;

        // fill memory; one word per bank per request (R2)
        for (int r = 0; r < ROWS; r++) begin
            for (int l = 0; l < LANES; l++) begin
                ta[l] = WA'(r * 32 + l);
                td[l] = $urandom;
            end
            run_req(4'd1, '1, "R2", 0);
        end

        // one bank, 32 rows: 32 passes (R2, R4)
        for (int l = 0; l < LANES; l++) ta[l] = WA'(l * 32 + 5);
        run_req(4'd0, '1, "R4", 1);

        // broadcast of one word (R5)
        for (int l = 0; l < LANES; l++) ta[l] = WA'(77);
        run_req(4'd0, '1, "R5", 1);
        // two words of one bank shared by halves: 2 passes
        for (int l = 0; l < LANES; l++) ta[l] = (l < 16) ? WA'(3) : WA'(35);
        run_req(4'd0, '1, "R5", 1);

        // 32-step atomic add chain on one word (R7)
        for (int l = 0; l < LANES; l++) begin ta[l] = WA'(100); td[l] = l + 1; end
        run_req(4'd2, '1, "R7", 1);

        // partial mask: upper lanes leave memory alone (R6)
        for (int l = 0; l < LANES; l++) begin ta[l] = WA'(400 + l); td[l] = 32'hA5A5_0000 + l; end
        run_req(4'd1, 32'h0000_FFFF, "R6", 1);
        run_req(4'd0, '1, "R6", 1);

        // float specials on lane 0 (R9)
        ta[0] = WA'(200);
        td[0] = 32'h7FC0_0000; run_req(4'd1, 32'h1, "R9", 1);
        td[0] = 32'h4040_0000; run_req(4'd9, 32'h1, "R9", 1);
        td[0] = 32'h7F80_0001; run_req(4'd10, 32'h1, "R9", 1);
        td[0] = 32'h0000_0000; run_req(4'd1, 32'h1, "R9", 1);
        td[0] = 32'h8000_0000; run_req(4'd9, 32'h1, "R9", 1);
        td[0] = 32'h0000_0000; run_req(4'd10, 32'h1, "R9", 1);
        td[0] = 32'hC000_0000; run_req(4'd9, 32'h1, "R9", 1);
        run_req(4'd0, 32'h1, "R9", 1);

        // random traffic
        for (int i = 0; i < 400; i++) begin
            logic [3:0] op;
            logic [31:0] mask;
            int mode;
            logic [WA-1:0] pool [4];
            op   = 4'($urandom % 11);
            mask = ($urandom % 3 == 0) ? '1 : $urandom;
            mode = $urandom % 3;
            for (int k = 0; k < 4; k++) pool[k] = WA'($urandom);
            for (int l = 0; l < LANES; l++) begin
                case (mode)
                    0: ta[l] = WA'($urandom);
                    1: ta[l] = pool[$urandom % 4];
                    default: ta[l] = {6'($urandom), pool[0][4:0]};
                endcase
                case ($urandom % 5)
                    0: td[l] = 32'h7FC0_0000 | 32'($urandom % 256);
                    1: td[l] = 32'h8000_0000;
                    2: td[l] = 32'($urandom % 16);
                    default: td[l] = $urandom;
                endcase
            end
            run_req(op, mask, op_tag(op), 1);
        end

        // full readback (R2)
        for (int r = 0; r < ROWS; r++) begin
            for (int l = 0; l < LANES; l++) ta[l] = WA'(r * 32 + l);
            run_req(4'd0, '1, "R2", 1);
        end

        finish_run();
    end

endmodule